// File: doc/BRIEF.md
# Selectable-Width Transmit Serializer

This block turns parallel transmit words coming from a framer into one line bit stream, timed by the line-rate bit clock. Two static mode inputs choose how it works. In bypass mode a serial input goes straight to the line. In the parallel modes an eight-lane word or a four-lane word is shifted out, with the most significant used lane first.

The block divides the bit clock to make a word clock. The framer launches each new parallel word on the rising edge of that clock. The serializer captures the word on the bit-clock edge where its divider wraps to zero. In bypass mode the word clock still runs, at one-eighth of the bit rate.

The mode inputs are sampled only while the synchronous reset is held. A mode change therefore takes effect after the next reset, and the divider and shift register restart cleanly from count zero.

Top module: `tx_serializer`

## Requirements
- R1: When the registered parallel select is 0 (bypass mode), `line_out` equals `ser_in` in the same cycle, and the width select has no effect.
- R2: In 8-lane mode, `word_clk` has a period of 8 bit clocks. It is low for the first 4 bit clocks after a wrap and high for the next 4.
- R3: In 4-lane mode, `word_clk` has a period of 4 bit clocks. It is low for 2 bit clocks and high for 2.
- R4: In bypass mode, `word_clk` still divides the bit clock by 8, with the same phase as in 8-lane mode.
- R5: In 8-lane mode, `par_data` is captured at the 8th bit-clock edge of each word period. Bits 7 down to 0 then appear on `line_out`, one per bit clock, starting right after that edge.
- R6: In 4-lane mode, `par_data` is captured at the 4th edge of each period. Bits 3 down to 0 then appear on `line_out`. Bits 7:4 never reach the line.
- R7: `sel_par` and `sel_wide` are sampled only on edges where `rst` is 1. Changing them while out of reset does not change the word period or the data path.
- R8: During reset and until the first capture, `line_out` is 0 in the parallel modes. During reset `word_clk` is 0, and the divider leaves reset at count zero.
- R9: Successive words go out back to back, with no idle bit between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Line-rate bit clock |
| rst | input | 1 | Synchronous reset, active high; also samples the mode inputs |
| sel_par | input | 1 | 1 = parallel modes, 0 = serial bypass |
| sel_wide | input | 1 | 1 = 8-lane words, 0 = 4-lane words (parallel only) |
| par_data | input | WORD_W | Parallel transmit word from the framer |
| ser_in | input | 1 | Serial transmit data for bypass mode |
| word_clk | output | 1 | Divided word clock for the framer |
| line_out | output | 1 | Serialized line bit |

## Verification
The assertions check, on every cycle:
- the divider count stays inside the active period;
- every capture is followed by count zero;
- falling edges of the word clock line up with the wrap;
- the latched mode holds between resets;
- the line is quiet right after reset;
- each shifted bit follows its neighbour.

Only the bench scenarios can show the lane order on the line, the exclusion of the upper lanes in 4-lane mode, the bypass path, and immunity to mode-pin changes made outside reset. The bench compares these against bit values computed from sweeps over every possible 8-bit word and every 4-bit word.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;

   typedef enum logic [1:0] {
      MODE_BYPASS = 2'd0,
      MODE_NARROW = 2'd1,
      MODE_WIDE   = 2'd2
   } tx_mode_e;

   function automatic tx_mode_e decode_mode(input logic par, input logic wide);
      if (!par)
         return MODE_BYPASS;
      else if (wide)
         return MODE_WIDE;
      else
         return MODE_NARROW;
   endfunction

endpackage

// File: rtl/tx_ser_divider.sv
module tx_ser_divider
   import tx_ser_pkg::*;
#(
   parameter int WORD_W   = 8,
   parameter int NARROW_W = 4,
   localparam int CNT_W   = $clog2(WORD_W)
) (
   input  logic             clk_bit,
   input  logic             rst,
   input  tx_mode_e         mode,
   output logic [CNT_W-1:0] cnt,
   output logic             word_clk,
   output logic             load
);

   localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_W - 1);
   localparam logic [CNT_W-1:0] WIDE_HALF   = CNT_W'(WORD_W / 2);
   localparam logic [CNT_W-1:0] NARROW_HALF = CNT_W'(NARROW_W / 2);

   logic [CNT_W-1:0] last;
   logic [CNT_W-1:0] half;
   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      last    = (mode == MODE_NARROW) ? NARROW_LAST : WIDE_LAST;
      half    = (mode == MODE_NARROW) ? NARROW_HALF : WIDE_HALF;
      load    = (cnt == last);
      cnt_nxt = load ? '0 : cnt + 1'b1;
   end

   always_ff @(posedge clk_bit) begin
      if (rst) begin
         cnt      <= '0;
         word_clk <= 1'b0;
      end else begin
         cnt      <= cnt_nxt;
         word_clk <= (cnt_nxt >= half);
      end
   end

   // R2 R3: count never leaves the active period
   p_cnt_range_r2: assert property (@(posedge clk_bit) disable iff (rst)
      cnt <= last);

   // R3: a capture always restarts the period
   p_wrap_zero_r3: assert property (@(posedge clk_bit) disable iff (rst)
      load |=> (cnt == '0));

   // R2: word clock falls only on the wrap
   p_wclk_fall_r2: assert property (@(posedge clk_bit) disable iff (rst)
      $fell(word_clk) |-> (cnt == '0));

endmodule

// File: rtl/tx_ser_shifter.sv
module tx_ser_shifter #(
   parameter int WORD_W = 8
) (
   input  logic              clk_bit,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   output logic              msb
);

   logic [WORD_W-1:0] sreg;

   always_ff @(posedge clk_bit) begin
      if (rst)
         sreg <= '0;
      else if (load)
         sreg <= load_word;
      else
         sreg <= {sreg[WORD_W-2:0], 1'b0};
   end

   assign msb = sreg[WORD_W-1];

   // R9: between captures each line bit is the neighbour of the last one
   p_shift_step_r9: assert property (@(posedge clk_bit) disable iff (rst)
      !load |=> (sreg[WORD_W-1] == $past(sreg[WORD_W-2])));

endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
   import tx_ser_pkg::*;
#(
   parameter int WORD_W   = 8,
   parameter int NARROW_W = 4
) (
   input  logic              clk_bit,
   input  logic              rst,
   input  logic              sel_par,
   input  logic              sel_wide,
   input  logic [WORD_W-1:0] par_data,
   input  logic              ser_in,
   output logic              word_clk,
   output logic              line_out
);

   localparam int CNT_W    = $clog2(WORD_W);
   localparam int LANE_OFS = WORD_W - NARROW_W;

   generate
      if ((WORD_W & (WORD_W - 1)) != 0 || WORD_W < 4)
         $error("WORD_W must be a power of two, at least 4");
      if ((NARROW_W & (NARROW_W - 1)) != 0 || NARROW_W < 2 || NARROW_W >= WORD_W)
         $error("NARROW_W must be a power of two in [2, WORD_W)");
   endgenerate

   tx_mode_e          mode_q;
   logic [CNT_W-1:0]  cnt;
   logic              load;
   logic [WORD_W-1:0] load_word;
   logic              shift_msb;

   // Mode inputs are sampled only under reset
   always_ff @(posedge clk_bit) begin
      if (rst)
         mode_q <= decode_mode(sel_par, sel_wide);
   end

   tx_ser_divider #(
      .WORD_W   (WORD_W),
      .NARROW_W (NARROW_W)
   ) u_div (
      .clk_bit  (clk_bit),
      .rst      (rst),
      .mode     (mode_q),
      .cnt      (cnt),
      .word_clk (word_clk),
      .load     (load)
   );

   // Lane steering: narrow words are aligned to the top so MSB leaves first
   generate
      for (genvar i = 0; i < WORD_W; i++) begin : g_lane
         if (i >= LANE_OFS) begin : g_upper
            assign load_word[i] = (mode_q == MODE_NARROW) ? par_data[i-LANE_OFS] : par_data[i];
         end else begin : g_lower
            assign load_word[i] = (mode_q == MODE_NARROW) ? 1'b0 : par_data[i];
         end
      end
   endgenerate

   tx_ser_shifter #(
      .WORD_W    (WORD_W)
   ) u_shift (
      .clk_bit   (clk_bit),
      .rst       (rst),
      .load      (load),
      .load_word (load_word),
      .msb       (shift_msb)
   );

   assign line_out = (mode_q == MODE_BYPASS) ? ser_in : shift_msb;

   // R7: latched mode does not move outside reset
   p_mode_hold_r7: assert property (@(posedge clk_bit)
      !rst |=> (rst || $stable(mode_q)));

   // R8: line is quiet on the first cycle after reset in parallel modes
   p_quiet_start_r8: assert property (@(posedge clk_bit) disable iff (rst)
      ($past(rst) && mode_q != MODE_BYPASS) |-> !line_out);

   // R8: divider leaves reset at count zero
   p_cnt_start_r8: assert property (@(posedge clk_bit) disable iff (rst)
      $past(rst) |-> (cnt == '0));

endmodule

// File: tb/tx_serializer_tb.sv
module tx_serializer_tb;

   logic       clk_bit = 1'b0;
   logic       rst = 1'b1;
   logic       sel_par = 1'b1;
   logic       sel_wide = 1'b1;
   logic [7:0] par_data = 8'h00;
   logic       ser_in = 1'b0;
   logic       word_clk;
   logic       line_out;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk_bit = ~clk_bit;

   tx_serializer u_dut (
      .clk_bit  (clk_bit),
      .rst      (rst),
      .sel_par  (sel_par),
      .sel_wide (sel_wide),
      .par_data (par_data),
      .ser_in   (ser_in),
      .word_clk (word_clk),
      .line_out (line_out)
   );

   task automatic check(input string req, input int k, input logic got, input logic exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s step=%0d got=%b exp=%b", req, k, got, exp);
      end
   endtask

   task automatic do_reset(input logic par, input logic wide);
      @(negedge clk_bit);
      rst = 1'b1; sel_par = par; sel_wide = wide;
      @(negedge clk_bit);
      @(negedge clk_bit);
      check("R8", -1, word_clk, 1'b0);
      if (par) check("R8", -1, line_out, 1'b0);
      rst = 1'b0;
   endtask

   function automatic logic [7:0] pat(input int w, input logic wide);
      if (wide) return 8'(w);
      return 8'((w * 8'd29) ^ 8'hA0);
   endfunction

   // Parallel run: n words. Mode pins are flipped at word flip_at (R7).
   task automatic run_par(input logic wide, input int nwords, input int flip_at);
      int n;
      n = wide ? 8 : 4;
      do_reset(1'b1, wide);
      for (int k = 0; k < n * (nwords + 1); k++) begin
         logic [7:0] word;
         logic exp_bit;
         int msb;
         msb = wide ? 7 : 3;
         check(wide ? "R2" : "R3", k, word_clk, (k % n) >= n / 2);
         if (k < n) begin
            exp_bit = 1'b0;
            check("R8", k, line_out, exp_bit);
         end else begin
            word = pat(k / n - 1, wide);
            exp_bit = word[msb - (k % n)];
            check(wide ? "R5 R9" : "R6 R9", k, line_out, exp_bit);
         end
         if (k / n == flip_at) begin
            sel_par = 1'b0; sel_wide = ~wide;
         end
         par_data = pat(k / n, wide);
         @(negedge clk_bit);
      end
      sel_par = 1'b1; sel_wide = wide;
   endtask

   task automatic run_bypass(input logic wide, input int ncyc);
      do_reset(1'b0, wide);
      for (int k = 0; k < ncyc; k++) begin
         check("R4", k, word_clk, (k % 8) >= 4);
         ser_in = 1'(((k * 7) ^ (k >> 2)) & 1);
         par_data = 8'(k * 13);
         sel_wide = 1'(k >> 3);
         #1;
         check("R1", k, line_out, ser_in);
         @(negedge clk_bit);
      end
   endtask

   initial begin
      run_par(1'b1, 256, 128);
      run_par(1'b0, 256, 200);
      run_bypass(1'b1, 64);
      run_bypass(1'b0, 64);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired got=hang exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule